// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fills a chip's configuration registers from a small serial EEPROM of the three-wire-plus-select kind (clock, select, data towards the memory, data from the memory). As soon as reset is released it reads word 0 of the memory. That word is a header: a 12-bit signature and three flags that say which optional register zones follow. Each zone present in the header is then read word by word from consecutive addresses. Every word read is handed to the register file through a one-cycle write strobe, together with the zone number and the word's index inside that zone.

Loading stops early when no memory answers or when the header signature is wrong. In both cases nothing is written and the registers keep their reset values. Once loading is over, the four memory pins pass to software-driven bits so a driver can bit-bang accesses. A reload request reruns the whole sequence exactly as a reset would.

The number of word address bits is a parameter (6 for a 64-word part, 8 for a 128-word part). The serial clock half-period, in system clocks, is also a parameter, and so are the three zone lengths.

Top module: `mw_cfg_loader`

## Requirements
- R1: A read transaction raises `ee_cs` and then presents, MSB first, a start bit 1, the opcode bits 1 then 0, and the ADDR_W-bit word address on `ee_di`. Each bit is valid at a rising edge of `ee_sk`, and `ee_sk` idles low. The first transaction after reset reads address 0.
- R2: The bit sampled on `ee_do` at the rising edge that follows the last address bit must be 0. If it is 1, no device is present: loading ends with `load_done`=1, `prog_valid`=0 and no register writes.
- R3: A header whose bits 15:4 differ from 0x950, including the all-ones word, ends loading with `load_done`=1, `prog_valid`=0 and no register writes.
- R4: A matching header sets `prog_valid` before any register write. The zone words are read from consecutive addresses starting at 1. Each word produces exactly one `cfg_we` cycle carrying `cfg_zone` (1, 2 or 3), `cfg_idx` (0-based within the zone) and `cfg_data` (the word).
- R5: Header bit 2 marks zone 1 (Z1_WORDS words), bit 1 marks zone 2 (Z2_WORDS words) and bit 0 marks zone 3 (Z3_WORDS words). Present zones are read in ascending zone order. A missing zone uses no addresses; for example, 0x9505 reads zone 1 from address 1 and zone 3 straight after it.
- R6: A matching header with all three zone flags clear sets `prog_valid` and `load_done` after reading only address 0, and makes no writes.
- R7: Header bit 3 has no effect on which words are read or written.
- R8: `ee_cs` changes only while `ee_sk` is low and was low in the previous cycle. Between two reads of one load, `ee_cs` stays low for at least 2×SK_HALF system clocks.
- R9: `reload_req` while `load_done`=1 clears `load_done` and `prog_valid` in the next cycle and reruns the whole sequence from address 0. `reload_req` during a load is ignored.
- R10: While `load_done`=1, `ee_cs`, `ee_sk` and `ee_di` equal the previous cycle's `sw_cs`, `sw_sk` and `sw_di`, and `sw_do` gives `ee_do` one cycle later. During a load the `sw_*` inputs do not reach the pins and `sw_do` is 0.
- R11: Reset clears `load_done`, `prog_valid` and `cfg_we` and starts a new load. Once `load_done` is high it stays high with no writes until a reload request or a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high bus reset; loading starts when it drops |
| reload_req | input | 1 | Software request to rerun the load |
| sw_cs | input | 1 | Software value for the select pin after loading |
| sw_sk | input | 1 | Software value for the serial clock pin after loading |
| sw_di | input | 1 | Software value for the data-to-memory pin after loading |
| sw_do | output | 1 | Registered data-from-memory pin for software |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data towards the memory |
| ee_do | input | 1 | Serial data from the memory (pulled high when absent) |
| cfg_we | output | 1 | One-cycle register write strobe |
| cfg_zone | output | 2 | Zone number of the written word |
| cfg_idx | output | ADDR_W | Word index within its zone |
| cfg_data | output | 16 | Word to write |
| prog_valid | output | 1 | Header signature matched |
| load_done | output | 1 | Loading finished or abandoned |

## Verification
The assertions check on every cycle the properties that do not depend on what the memory holds. They cover the select-versus-clock edge rule, writes happening only with a valid program and never after completion, the persistence of completion, the reload restart, and the software pin hand-over. The order of zones, the skipping of missing zones, the handling of the reserved header bit, the read addresses and command bits, the chip-select gap, and the three ways loading can be abandoned depend on the memory contents. Only the bench's scenarios can show those: a behavioural memory model answers the serial reads, and a reference model predicts the write stream from the header.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int unsigned WORD_W = 16;
  localparam logic [11:0] SIGNATURE = 12'h950;

  typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_END, E_GAP} xfer_st_t;
  typedef enum logic [2:0] {Q_HDR_REQ, Q_HDR_WAIT, Q_ZN_REQ, Q_ZN_WAIT, Q_FIN, Q_DONE} walk_st_t;

  // Returns the first present zone above cur, or 0 when none remains.
  // Flag bit (3 - zone) marks a zone as present.
  function automatic logic [1:0] next_zone(input logic [2:0] fl, input logic [1:0] cur);
    logic [1:0] r;
    r = 2'd0;
    for (int z = 3; z >= 1; z--) begin
      if ((2'(z) > cur) && fl[3-z]) r = 2'(z);
    end
    return r;
  endfunction
endpackage

// File: rtl/mw_clk_div.sv
module mw_clk_div #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (HALF <= 1) begin : g_every
      assign tick = ~rst;
    end else begin : g_count
      localparam int unsigned CW = $clog2(HALF);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else if (cnt == CW'(HALF - 1)) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == CW'(HALF - 1)) & ~rst;
    end
  endgenerate
endmodule

// File: rtl/mw_xfer.sv
module mw_xfer
  import mw_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              req,
  input  logic [AW-1:0]     addr,
  input  logic              ee_do,
  output logic              taken,
  output logic              cs,
  output logic              sk,
  output logic              di,
  output logic              word_vld,
  output logic [WORD_W-1:0] word,
  output logic              no_dev
);
  localparam int unsigned CMD_BITS = 3 + AW;
  localparam int unsigned LAST_RISE = CMD_BITS + WORD_W;
  localparam int unsigned RW = $clog2(LAST_RISE + 2);
  localparam int unsigned SRW = 2 + AW;

  xfer_st_t          st;
  logic [RW-1:0]     rise_cnt;
  logic [SRW-1:0]    cmd_sr;
  logic [WORD_W-1:0] data_sr;
  logic              gap_cnt;

  assign taken = (st == E_IDLE) && tick && req;
  assign word  = data_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= E_IDLE;
      cs       <= 1'b0;
      sk       <= 1'b0;
      di       <= 1'b0;
      rise_cnt <= '0;
      cmd_sr   <= '0;
      data_sr  <= '0;
      no_dev   <= 1'b0;
      gap_cnt  <= 1'b0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      case (st)
        E_IDLE: begin
          if (taken) begin
            cs       <= 1'b1;
            sk       <= 1'b0;
            di       <= 1'b1;
            cmd_sr   <= {2'b10, addr};
            rise_cnt <= '0;
            no_dev   <= 1'b0;
            st       <= E_SHIFT;
          end
        end
        E_SHIFT: begin
          if (tick) begin
            if (!sk) begin
              sk       <= 1'b1;
              rise_cnt <= rise_cnt + 1'b1;
              if (rise_cnt == RW'(CMD_BITS)) no_dev <= ee_do;
              else if (rise_cnt > RW'(CMD_BITS)) data_sr <= {data_sr[WORD_W-2:0], ee_do};
            end else begin
              sk <= 1'b0;
              if (rise_cnt == RW'(LAST_RISE + 1)) begin
                di <= 1'b0;
                st <= E_END;
              end else begin
                di     <= cmd_sr[SRW-1];
                cmd_sr <= {cmd_sr[SRW-2:0], 1'b0};
              end
            end
          end
        end
        E_END: begin
          if (tick) begin
            cs       <= 1'b0;
            word_vld <= 1'b1;
            gap_cnt  <= 1'b0;
            st       <= E_GAP;
          end
        end
        default: begin
          if (tick) begin
            if (gap_cnt) st <= E_IDLE;
            else gap_cnt <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mw_zone_walk.sv
module mw_zone_walk
  import mw_pkg::*;
#(
  parameter int unsigned AW  = 6,
  parameter int unsigned Z1N = 2,
  parameter int unsigned Z2N = 4,
  parameter int unsigned Z3N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reload_req,
  input  logic              taken,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  input  logic              no_dev,
  output logic              req,
  output logic [AW-1:0]     rd_addr,
  output logic              cfg_we,
  output logic [1:0]        cfg_zone,
  output logic [AW-1:0]     cfg_idx,
  output logic [WORD_W-1:0] cfg_data,
  output logic              prog_valid,
  output logic              load_done
);
  walk_st_t      st;
  logic [1:0]    zone;
  logic [AW-1:0] idx;
  logic [2:0]    flags;
  logic [1:0]    nz_hdr;
  logic [1:0]    nz_cur;
  logic [AW-1:0] zlen;

  always_comb begin
    nz_hdr = next_zone(word[2:0], 2'd0);
    nz_cur = next_zone(flags, zone);
    case (zone)
      2'd1:    zlen = AW'(Z1N);
      2'd2:    zlen = AW'(Z2N);
      default: zlen = AW'(Z3N);
    endcase
  end

  assign req = (st == Q_HDR_REQ) || (st == Q_ZN_REQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= Q_HDR_REQ;
      zone       <= 2'd0;
      idx        <= '0;
      flags      <= 3'd0;
      rd_addr    <= '0;
      cfg_we     <= 1'b0;
      cfg_zone   <= 2'd0;
      cfg_idx    <= '0;
      cfg_data   <= '0;
      prog_valid <= 1'b0;
      load_done  <= 1'b0;
    end else begin
      cfg_we <= 1'b0;
      case (st)
        Q_HDR_REQ: if (taken) st <= Q_HDR_WAIT;
        Q_HDR_WAIT: begin
          if (word_vld) begin
            if (no_dev || (word[15:4] != SIGNATURE)) begin
              st <= Q_FIN;
            end else begin
              prog_valid <= 1'b1;
              flags      <= word[2:0];
              if (nz_hdr == 2'd0) begin
                st <= Q_FIN;
              end else begin
                zone    <= nz_hdr;
                idx     <= '0;
                rd_addr <= rd_addr + 1'b1;
                st      <= Q_ZN_REQ;
              end
            end
          end
        end
        Q_ZN_REQ: if (taken) st <= Q_ZN_WAIT;
        Q_ZN_WAIT: begin
          if (word_vld) begin
            if (no_dev) begin
              st <= Q_FIN;
            end else begin
              cfg_we   <= 1'b1;
              cfg_zone <= zone;
              cfg_idx  <= idx;
              cfg_data <= word;
              rd_addr  <= rd_addr + 1'b1;
              if (idx == zlen - 1'b1) begin
                if (nz_cur == 2'd0) begin
                  st <= Q_FIN;
                end else begin
                  zone <= nz_cur;
                  idx  <= '0;
                  st   <= Q_ZN_REQ;
                end
              end else begin
                idx <= idx + 1'b1;
                st  <= Q_ZN_REQ;
              end
            end
          end
        end
        Q_FIN: begin
          load_done <= 1'b1;
          st        <= Q_DONE;
        end
        default: begin
          if (reload_req) begin
            load_done  <= 1'b0;
            prog_valid <= 1'b0;
            rd_addr    <= '0;
            zone       <= 2'd0;
            st         <= Q_HDR_REQ;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mw_cfg_loader.sv
module mw_cfg_loader
  import mw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned SK_HALF  = 2,
  parameter int unsigned Z1_WORDS = 2,
  parameter int unsigned Z2_WORDS = 4,
  parameter int unsigned Z3_WORDS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reload_req,
  input  logic              sw_cs,
  input  logic              sw_sk,
  input  logic              sw_di,
  output logic              sw_do,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do,
  output logic              cfg_we,
  output logic [1:0]        cfg_zone,
  output logic [ADDR_W-1:0] cfg_idx,
  output logic [15:0]       cfg_data,
  output logic              prog_valid,
  output logic              load_done
);
  logic              tick;
  logic              req;
  logic              taken;
  logic [ADDR_W-1:0] rd_addr;
  logic              x_cs;
  logic              x_sk;
  logic              x_di;
  logic              word_vld;
  logic [WORD_W-1:0] word;
  logic              no_dev;

  mw_clk_div #(.HALF(SK_HALF)) u_div (
    .clk(clk), .rst(rst), .tick(tick)
  );

  mw_xfer #(.AW(ADDR_W)) u_xfer (
    .clk(clk), .rst(rst), .tick(tick), .req(req), .addr(rd_addr),
    .ee_do(ee_do), .taken(taken), .cs(x_cs), .sk(x_sk), .di(x_di),
    .word_vld(word_vld), .word(word), .no_dev(no_dev)
  );

  mw_zone_walk #(.AW(ADDR_W), .Z1N(Z1_WORDS), .Z2N(Z2_WORDS), .Z3N(Z3_WORDS)) u_walk (
    .clk(clk), .rst(rst), .reload_req(reload_req), .taken(taken),
    .word_vld(word_vld), .word(word), .no_dev(no_dev), .req(req),
    .rd_addr(rd_addr), .cfg_we(cfg_we), .cfg_zone(cfg_zone),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .prog_valid(prog_valid),
    .load_done(load_done)
  );

  // Pin ownership: loader during a load, software bits afterwards.
  always_ff @(posedge clk) begin
    if (rst) begin
      ee_cs <= 1'b0;
      ee_sk <= 1'b0;
      ee_di <= 1'b0;
      sw_do <= 1'b0;
    end else if (load_done) begin
      ee_cs <= sw_cs;
      ee_sk <= sw_sk;
      ee_di <= sw_di;
      sw_do <= ee_do;
    end else begin
      ee_cs <= x_cs;
      ee_sk <= x_sk;
      ee_di <= x_di;
      sw_do <= 1'b0;
    end
  end
endmodule

// File: rtl/mw_cfg_loader_chk.sv
module mw_cfg_loader_chk (
  input logic clk,
  input logic rst,
  input logic reload_req,
  input logic load_done,
  input logic prog_valid,
  input logic cfg_we,
  input logic x_cs,
  input logic x_sk,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di,
  input logic sw_cs,
  input logic sw_sk,
  input logic sw_di
);
  a_r8_cs_moves_sk_low: assert property (@(posedge clk) disable iff (rst)
    (x_cs != $past(x_cs)) |-> (!x_sk && !$past(x_sk)));

  a_r4_write_needs_valid: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> prog_valid);

  a_r11_no_write_when_done: assert property (@(posedge clk) disable iff (rst)
    load_done |-> !cfg_we);

  a_r11_done_holds: assert property (@(posedge clk) disable iff (rst)
    (load_done && !reload_req) |=> load_done);

  a_r9_reload_restarts: assert property (@(posedge clk) disable iff (rst)
    (load_done && reload_req) |=> (!load_done && !prog_valid));

  a_r10_pins_follow_sw: assert property (@(posedge clk) disable iff (rst)
    $past(load_done) |-> (ee_cs == $past(sw_cs) && ee_sk == $past(sw_sk) && ee_di == $past(sw_di)));
endmodule

bind mw_cfg_loader mw_cfg_loader_chk u_chk (
  .clk(clk), .rst(rst), .reload_req(reload_req), .load_done(load_done),
  .prog_valid(prog_valid), .cfg_we(cfg_we), .x_cs(x_cs), .x_sk(x_sk),
  .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .sw_cs(sw_cs),
  .sw_sk(sw_sk), .sw_di(sw_di)
);

// File: tb/tb_mw_cfg_loader.sv
`timescale 1ns/1ps
module tb_mw_cfg_loader;
  localparam int AW = 6;
  localparam int HALF = 2;
  localparam int CMDB = 3 + AW;
  localparam int L1 = 2, L2 = 4, L3 = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reload_req = 1'b0;
  logic sw_cs = 1'b0, sw_sk = 1'b0, sw_di = 1'b0;
  logic sw_do, ee_cs, ee_sk, ee_di, ee_do;
  logic cfg_we;
  logic [1:0] cfg_zone;
  logic [AW-1:0] cfg_idx;
  logic [15:0] cfg_data;
  logic prog_valid, load_done;

  int n_checks = 0;
  int n_fail = 0;

  // Memory model state
  logic [15:0] mem [0:63];
  bit dev_present = 1'b1;
  logic model_do = 1'b1;
  bit ovr_en = 1'b0;
  logic ovr_val = 1'b0;
  int rc = 0;
  logic [31:0] cmd_cap = '0;
  logic [CMDB-1:0] cmd_q[$];
  realtime t_fall = 0.0;

  // Reference model state
  logic [23:0] exp_q[$];
  logic exp_valid;
  int exp_ncmd;

  always #2 clk = ~clk;

  assign ee_do = ovr_en ? ovr_val : (dev_present ? model_do : 1'b1);

  mw_cfg_loader #(.ADDR_W(AW), .SK_HALF(HALF), .Z1_WORDS(L1), .Z2_WORDS(L2), .Z3_WORDS(L3)) dut (
    .clk(clk), .rst(rst), .reload_req(reload_req), .sw_cs(sw_cs), .sw_sk(sw_sk),
    .sw_di(sw_di), .sw_do(sw_do), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do), .cfg_we(cfg_we), .cfg_zone(cfg_zone), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .prog_valid(prog_valid), .load_done(load_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural serial memory
  always @(posedge ee_cs) begin
    if (!load_done && t_fall > 0.0) chk("R8 select gap >= 2 half periods", 32'(($realtime - t_fall) >= 16.0), 1);
    rc = 0;
    cmd_cap = '0;
  end

  always @(negedge ee_cs) begin
    if (rc >= CMDB) cmd_q.push_back(cmd_cap[CMDB-1:0]);
    rc = 0;
    model_do = 1'b1;
    t_fall = $realtime;
  end

  always @(posedge ee_sk) begin
    if (ee_cs) begin
      if (rc < CMDB) cmd_cap = {cmd_cap[30:0], ee_di};
      if (rc == CMDB - 1) model_do = 1'b0;
      else if (rc >= CMDB && rc < CMDB + 16) model_do = mem[cmd_cap[AW-1:0]][15 - (rc - CMDB)];
      else model_do = 1'b1;
      rc++;
    end
  end

  function automatic int zlen(input int z);
    return (z == 1) ? L1 : ((z == 2) ? L2 : L3);
  endfunction

  task automatic build_expect();
    logic [15:0] h;
    int a;
    h = mem[0];
    exp_q.delete();
    cmd_q.delete();
    exp_valid = dev_present && (h[15:4] == 12'h950);
    a = 1;
    if (exp_valid) begin
      for (int z = 1; z <= 3; z++) begin
        if (h[3-z]) begin
          for (int i = 0; i < zlen(z); i++) begin
            exp_q.push_back({2'(z), 6'(i), mem[a]});
            a++;
          end
        end
      end
    end
    exp_ncmd = dev_present ? a : 0;
  endtask

  // Write stream compared against the reference every clock
  always @(negedge clk) begin
    if (!rst && cfg_we) begin
      if (exp_q.size() == 0) begin
        chk("R4 unexpected write", {8'h0, cfg_zone, cfg_idx, cfg_data}, 32'hdead);
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk("R4 R5 write zone/idx/data", {8'h0, cfg_zone, cfg_idx, cfg_data}, {8'h0, e});
      end
    end
  end

  task automatic finish_load(input string tag);
    int n;
    n = 0;
    while (!load_done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    chk({tag, " done"}, 32'(load_done), 1);
    chk({tag, " valid"}, 32'(prog_valid), 32'(exp_valid));
    chk({tag, " writes left"}, exp_q.size(), 0);
    if (dev_present) begin
      chk({tag, " R1 read count"}, cmd_q.size(), exp_ncmd);
      for (int i = 0; i < exp_ncmd && cmd_q.size() > 0; i++) begin
        logic [CMDB-1:0] c;
        c = cmd_q.pop_front();
        chk({tag, " R1 command bits"}, 32'(c), 32'({3'b110, 6'(i)}));
      end
    end
  endtask

  task automatic do_reload();
    @(negedge clk);
    reload_req = 1'b1;
    @(negedge clk);
    reload_req = 1'b0;
    chk("R9 reload clears done", 32'(load_done), 0);
    chk("R9 reload clears valid", 32'(prog_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h1111 + 16'h0357);
    mem[0] = 16'h9507;
    build_expect();
    sw_cs = 1'b1; sw_sk = 1'b1; sw_di = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 reset done", 32'(load_done), 0);
    chk("R11 reset valid", 32'(prog_valid), 0);
    chk("R11 reset write", 32'(cfg_we), 0);
    chk("R10 reset select", 32'(ee_cs), 0);
    rst = 1'b0;

    // All zones, software inputs held high during load
    repeat (200) @(negedge clk);
    chk("R10 sw_do during load", 32'(sw_do), 0);
    finish_load("R4 header 9507");
    sw_cs = 1'b0; sw_sk = 1'b0; sw_di = 1'b0;

    // Zone 2 missing
    mem[0] = 16'h9505;
    build_expect();
    do_reload();
    finish_load("R5 header 9505");

    // Reserved bit set, plus reload during load
    mem[0] = 16'h950F;
    build_expect();
    do_reload();
    repeat (300) @(negedge clk);
    reload_req = 1'b1;
    @(negedge clk);
    reload_req = 1'b0;
    finish_load("R7 R9 header 950F");

    // No zones
    mem[0] = 16'h9500;
    build_expect();
    do_reload();
    finish_load("R6 header 9500");

    // Bad signature, then all ones
    mem[0] = 16'h1234;
    build_expect();
    do_reload();
    finish_load("R3 header 1234");
    mem[0] = 16'hFFFF;
    build_expect();
    do_reload();
    finish_load("R3 header FFFF");

    // Absent device, restarted by reset
    dev_present = 1'b0;
    build_expect();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R11 reset clears done", 32'(load_done), 0);
    rst = 1'b0;
    finish_load("R2 absent device");
    dev_present = 1'b1;

    // Software pin access
    @(negedge clk);
    sw_cs = 1'b1; sw_sk = 1'b0; sw_di = 1'b1;
    ovr_en = 1'b1; ovr_val = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 select follows", 32'(ee_cs), 1);
    chk("R10 clock follows", 32'(ee_sk), 0);
    chk("R10 data follows", 32'(ee_di), 1);
    chk("R10 sw_do low", 32'(sw_do), 0);
    sw_sk = 1'b1; sw_di = 1'b0; ovr_val = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 clock follows high", 32'(ee_sk), 1);
    chk("R10 data follows low", 32'(ee_di), 0);
    chk("R10 sw_do high", 32'(sw_do), 1);
    chk("R11 done held", 32'(load_done), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule